// File: doc/BRIEF.md
# Interrupt Expansion Priority Mapper

This block gathers a wide set of level-sensitive peripheral interrupt lines and condenses them onto a narrower bank of central request channels. Each source line has its own programmable routing field naming the central channel it drives. Several sources may share one central channel; the channel is then active while any of them is active. After routing, each central channel passes through an individual enable and is tagged as either a fast or a normal request.

Two independent fixed-priority arbiters then look at the enabled channels. One looks at the fast-typed channels and the other at the normal-typed ones. Each arbiter drives a request flag and the binary number of the winning channel, where a lower channel number always wins. Software sets up routing, enables and types through a simple register port with a combinational read path. All of these are plain control pins; the block has no streaming interface and applies no back-pressure.

Top module: `irq_expand_mapper`

## Requirements
- R1: After reset, sources 0 to 31 route to the central channel of the same number and sources 32 to 47 route to channel 31. Every channel is disabled and typed normal, and both request outputs are low.
- R2: The routing field of source s sits at register address s (0 to 47), bits [4:0]. A write lands on the next clock edge. A read returns the field with all upper bits zero.
- R3: A central channel is pending while any source routed to it is high.
- R4: The enable register at address 0x40 holds bit c = 1 to let channel c through. A disabled channel never shows on either output.
- R5: The type register at address 0x41 holds bit c = 1 for a fast channel and 0 for a normal one.
- R6: Each output reports the lowest-numbered channel that is pending, enabled and of its own type.
- R7: The fast and normal outputs are arbitrated independently, so both may be high at once with different indices.
- R8: Both outputs are registered. A change at src_irq shows after one clock edge. A configuration write shows one edge after the edge that stores it.
- R9: Writes to any address other than 0 to 47, 0x40 or 0x41 change nothing, and reads from such addresses return zero.
- R10: Whenever a request output is low, its index output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | 48 | Level-sensitive source request lines |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| fast_req | output | 1 | A fast-typed channel is pending and enabled |
| fast_idx | output | 5 | Number of the winning fast channel |
| norm_req | output | 1 | A normal-typed channel is pending and enabled |
| norm_idx | output | 5 | Number of the winning normal channel |

## Verification
The hardest case to reach from the ports is sharing. In that case two upper sources and one lower source all drive the same central channel, and that channel must still win only when no lower enabled channel is pending. The bench gets there by rewriting routing fields so that two sources land on one channel. It then enables only that channel and toggles each source alone and together. Latency on the configuration path is checked by sampling on both sides of the edge after a disable write. This shows that the stored value reaches the output one cycle after the store.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int unsigned CLASS_CNT  = 2;
  localparam int unsigned CLASS_FAST = 0;
  localparam int unsigned CLASS_NORM = 1;
endpackage

// File: rtl/irqx_cfg_regs.sv
module irqx_cfg_regs #(
  parameter int unsigned NUM_SRC   = 48,
  parameter int unsigned NUM_CH    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned EN_ADDR   = 64,
  parameter int unsigned FAST_ADDR = 65,
  localparam int unsigned CH_W     = $clog2(NUM_CH),
  localparam int unsigned SRC_IW   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_SRC*CH_W-1:0]   route_flat,
  output logic [NUM_CH-1:0]         ch_en,
  output logic [NUM_CH-1:0]         ch_fast
);

  logic [CH_W-1:0]   route_q [NUM_SRC];
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] fast_q;
  logic              in_route_range;
  logic              unused_wdata_bits;

  assign in_route_range    = (addr < ADDR_W'(NUM_SRC));
  assign unused_wdata_bits = ^wdata;

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_route
      localparam int unsigned RST_CH = (s < NUM_CH) ? s : NUM_CH - 1;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          route_q[s] <= CH_W'(RST_CH);
        end else if (wr_en && addr == ADDR_W'(s)) begin
          route_q[s] <= wdata[CH_W-1:0];
        end
      end
      assign route_flat[s*CH_W +: CH_W] = route_q[s];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      fast_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(EN_ADDR))   en_q   <= wdata[NUM_CH-1:0];
      if (addr == ADDR_W'(FAST_ADDR)) fast_q <= wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (in_route_range) begin
      rdata[CH_W-1:0] = route_q[addr[SRC_IW-1:0]];
    end else if (addr == ADDR_W'(EN_ADDR)) begin
      rdata[NUM_CH-1:0] = en_q;
    end else if (addr == ADDR_W'(FAST_ADDR)) begin
      rdata[NUM_CH-1:0] = fast_q;
    end
  end

  assign ch_en   = en_q;
  assign ch_fast = fast_q;

  p_route_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_route_range) |=>
      route_q[$past(addr[SRC_IW-1:0])] == $past(wdata[CH_W-1:0]));

  p_enable_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(EN_ADDR)) |=> en_q == $past(wdata[NUM_CH-1:0]));

  p_type_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(FAST_ADDR)) |=> fast_q == $past(wdata[NUM_CH-1:0]));

  p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_route_range && addr != ADDR_W'(EN_ADDR) && addr != ADDR_W'(FAST_ADDR))
      |=> ($stable(en_q) && $stable(fast_q)));

endmodule

// File: rtl/irqx_fold.sv
module irqx_fold #(
  parameter int unsigned NUM_SRC = 48,
  parameter int unsigned NUM_CH  = 32,
  localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_SRC-1:0]        src,
  input  logic [NUM_SRC*CH_W-1:0]   route_flat,
  output logic [NUM_CH-1:0]         pend
);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      always_comb begin
        pend[c] = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
          if (src[s] && route_flat[s*CH_W +: CH_W] == CH_W'(c)) pend[c] = 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    if (src == '0) p_fold_idle_r3: assert (pend == '0);
  end

endmodule

// File: rtl/irqx_pick.sv
module irqx_pick #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    hit = |req;
  end

  always_comb begin
    if (hit) begin
      p_winner_set_r6: assert (req[idx]);
      p_winner_lowest_r6: assert ((req & ((W'(1) << idx) - W'(1))) == '0);
    end
  end

endmodule

// File: rtl/irq_expand_mapper.sv
module irq_expand_mapper
  import irqx_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 48,
  parameter int unsigned NUM_CH    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned EN_ADDR   = 64,
  parameter int unsigned FAST_ADDR = 65,
  localparam int unsigned CH_W     = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               cfg_wr_en,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               fast_req,
  output logic [CH_W-1:0]    fast_idx,
  output logic               norm_req,
  output logic [CH_W-1:0]    norm_idx
);

  logic [NUM_SRC*CH_W-1:0] route_flat;
  logic [NUM_CH-1:0]       ch_en;
  logic [NUM_CH-1:0]       ch_fast;
  logic [NUM_CH-1:0]       pend;
  logic [NUM_CH-1:0]       cls_req [CLASS_CNT];
  logic                    cls_hit [CLASS_CNT];
  logic [CH_W-1:0]         cls_idx [CLASS_CNT];
  logic                    req_q   [CLASS_CNT];
  logic [CH_W-1:0]         idx_q   [CLASS_CNT];

  irqx_cfg_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .EN_ADDR(EN_ADDR), .FAST_ADDR(FAST_ADDR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .route_flat(route_flat),
    .ch_en(ch_en), .ch_fast(ch_fast)
  );

  irqx_fold #(.NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH)) u_fold (
    .src(src_irq), .route_flat(route_flat), .pend(pend)
  );

  assign cls_req[CLASS_FAST] = pend & ch_en & ch_fast;
  assign cls_req[CLASS_NORM] = pend & ch_en & ~ch_fast;

  genvar g;
  generate
    for (g = 0; g < CLASS_CNT; g++) begin : g_class
      irqx_pick #(.W(NUM_CH)) u_pick (
        .req(cls_req[g]), .hit(cls_hit[g]), .idx(cls_idx[g])
      );
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          req_q[g] <= 1'b0;
          idx_q[g] <= '0;
        end else begin
          req_q[g] <= cls_hit[g];
          idx_q[g] <= cls_hit[g] ? cls_idx[g] : '0;
        end
      end
    end
  endgenerate

  assign fast_req = req_q[CLASS_FAST];
  assign fast_idx = idx_q[CLASS_FAST];
  assign norm_req = req_q[CLASS_NORM];
  assign norm_idx = idx_q[CLASS_NORM];

  p_fast_idx_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_req |-> fast_idx == '0);

  p_norm_idx_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_req |-> norm_idx == '0);

  p_all_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en == '0) |=> (!fast_req && !norm_req));

  p_no_fast_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_fast == '0) |=> !fast_req);

  p_no_norm_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_fast == '1) |=> !norm_req);

  p_quiet_sources_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq == '0) |=> (!fast_req && !norm_req));

endmodule

// File: tb/irq_expand_mapper_bench.sv
module irq_expand_mapper_bench;

  localparam int unsigned EN_A   = 8'h40;
  localparam int unsigned FAST_A = 8'h41;
  localparam int unsigned NV     = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] src_irq = '0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fast_req, norm_req;
  logic [4:0]  fast_idx, norm_idx;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_expand_mapper u_irq_expand_mapper (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fast_req(fast_req), .fast_idx(fast_idx), .norm_req(norm_req), .norm_idx(norm_idx)
  );

  // {src[48], enable[32], type[32], fast_req, fast_idx[5], norm_req, norm_idx[5]}
  localparam logic [123:0] VECS [NV] = '{
    {48'h0000_0000_0005, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0,  1'b1, 5'd0},
    {48'h0000_0000_0005, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 5'd0,  1'b1, 5'd2},
    {48'h0000_0000_0005, 32'hFFFF_FFFE, 32'h0000_0001, 1'b0, 5'd0,  1'b1, 5'd2},
    {48'h0100_0000_0000, 32'h8000_0000, 32'h0000_0000, 1'b0, 5'd0,  1'b1, 5'd31},
    {48'h0100_0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 5'd31, 1'b0, 5'd0},
    {48'h0000_0002_0220, 32'hFFFF_FFFF, 32'h0000_0200, 1'b1, 5'd9,  1'b1, 5'd5},
    {48'hFFFF_FFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 5'd0,  1'b0, 5'd0},
    {48'h8000_8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b0, 5'd0,  1'b1, 5'd31},
    {48'h0000_0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0,  1'b0, 5'd0},
    {48'h0000_0000_0018, 32'hFFFF_FFF7, 32'h0000_0010, 1'b1, 5'd4,  1'b0, 5'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic fr, input logic [4:0] fi,
                           input logic nr, input logic [4:0] ni);
    check({tag, " fast_req"}, {31'd0, fast_req}, {31'd0, fr});
    check({tag, " fast_idx"}, {27'd0, fast_idx}, {27'd0, fi});
    check({tag, " norm_req"}, {31'd0, norm_req}, {31'd0, nr});
    check({tag, " norm_idx"}, {27'd0, norm_idx}, {27'd0, ni});
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic set_src(input logic [47:0] v);
    @(negedge clk);
    src_irq = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    // R1: reset state
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 1'b0, 5'd0, 1'b0, 5'd0);
    rst_n = 1'b1;
    src_irq = 48'hFFFF_FFFF_FFFF;
    @(negedge clk); @(negedge clk);
    check_out("R1 all disabled after reset", 1'b0, 5'd0, 1'b0, 5'd0);
    cfg_read(8'd5, rd);  check("R1 route 5 default", rd, 32'd5);
    cfg_read(8'd31, rd); check("R1 route 31 default", rd, 32'd31);
    cfg_read(8'd40, rd); check("R1 route 40 default", rd, 32'd31);
    cfg_read(8'(EN_A), rd);   check("R1 enable default", rd, 32'd0);
    cfg_read(8'(FAST_A), rd); check("R1 type default", rd, 32'd0);

    // R4 R5 R6 R7 R10: vector walk on default routing
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      src_irq = VECS[v][123:76];
      cfg_write(8'(EN_A), VECS[v][75:44]);
      cfg_write(8'(FAST_A), VECS[v][43:12]);
      @(negedge clk);
      check_out($sformatf("R6 R7 vector %0d", v), VECS[v][11], VECS[v][10:6],
                VECS[v][5], VECS[v][4:0]);
    end

    // R2: route field write and readback
    cfg_write(8'd40, 32'hFFFF_FFE3);
    cfg_read(8'd40, rd); check("R2 route 40 readback", rd, 32'd3);
    cfg_write(8'(EN_A), 32'hFFFF_FFFF);
    cfg_write(8'(FAST_A), 32'h0);
    set_src(48'h0100_0000_0000);
    check_out("R2 source 40 on channel 3", 1'b0, 5'd0, 1'b1, 5'd3);
    set_src(48'h0100_0000_0004);
    check_out("R2 channel 2 beats rerouted 3", 1'b0, 5'd0, 1'b1, 5'd2);

    // R3: sharing one channel
    cfg_write(8'd33, 32'd7);
    cfg_write(8'd40, 32'd7);
    cfg_write(8'(EN_A), 32'h0000_0080);
    set_src(48'h0002_0000_0000);
    check_out("R3 source 33 alone", 1'b0, 5'd0, 1'b1, 5'd7);
    set_src(48'h0100_0000_0000);
    check_out("R3 source 40 alone", 1'b0, 5'd0, 1'b1, 5'd7);
    set_src(48'h0102_0000_0080);
    check_out("R3 three sources shared", 1'b0, 5'd0, 1'b1, 5'd7);
    set_src(48'h0001_0000_0000);
    check_out("R3 source 32 on disabled 31", 1'b0, 5'd0, 1'b0, 5'd0);

    // R8: latency of source and configuration paths
    cfg_write(8'(EN_A), 32'hFFFF_FFFF);
    set_src(48'h0);
    @(negedge clk);
    src_irq = 48'h0000_0000_1000;
    #1;
    check_out("R8 before edge", 1'b0, 5'd0, 1'b0, 5'd0);
    @(negedge clk);
    check_out("R8 one edge after source", 1'b0, 5'd0, 1'b1, 5'd12);
    cfg_write(8'(EN_A), 32'h0);
    check_out("R8 at store edge old config", 1'b0, 5'd0, 1'b1, 5'd12);
    @(negedge clk);
    check_out("R8 one edge after store", 1'b0, 5'd0, 1'b0, 5'd0);

    // R9: stray address
    cfg_write(8'(EN_A), 32'h0000_1000);
    cfg_write(8'h50, 32'hFFFF_FFFF);
    cfg_write(8'd48, 32'hFFFF_FFFF);
    cfg_read(8'h50, rd); check("R9 stray read", rd, 32'd0);
    cfg_read(8'd48, rd); check("R9 read past routes", rd, 32'd0);
    cfg_read(8'(EN_A), rd); check("R9 enable untouched", rd, 32'h0000_1000);
    cfg_read(8'(FAST_A), rd); check("R9 type untouched", rd, 32'd0);
    check_out("R9 output unchanged", 1'b0, 5'd0, 1'b1, 5'd12);

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_out("R1 mid-run reset", 1'b0, 5'd0, 1'b0, 5'd0);
    cfg_read(8'd40, rd); check("R1 route 40 restored", rd, 32'd31);
    cfg_read(8'd33, rd); check("R1 route 33 restored", rd, 32'd31);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule